// File: doc/BRIEF.md
# Byte-Wide Command/Response Mailbox Port

This block is the device-side logic of a two-address, byte-wide host I/O port. Through it, a host delivers framed command packets to a security coprocessor and collects framed responses. The host side has one address bit, a read strobe, a write strobe and 8-bit data. Address 0 is the data register. Address 1 reads back a status byte and, when written, takes a control code.

A host write of the start code opens a command. The payload bytes written to the data register then travel to the coprocessor over a valid/ready byte stream. The end code closes the command. The port then frames the response: a start marker byte, the payload bytes the coprocessor pushes, and an end marker byte. A status flag tells the host whether the byte waiting in the data register is a marker or payload. A cancel code returns the port to idle from any state.

Top module: `mbox_port`

## Requirements
- R1: Address 1 reads the status byte: bit0 output-full, bit1 input-full, bit2 marker (byte waiting is a frame marker), bit3 control-held (the held input byte came from the command register), bit4 ready-for-command (port idle), bit5 accepting-data (command phase), bits 7:6 zero. After reset the status reads 0x10.
- R2: Writing 0x01 to address 1 while idle enters the command phase: ready-for-command clears and accepting-data sets. The 0x01 code written in any other phase has no effect.
- R3: In the command phase, a data write while input-full is clear holds the byte, sets input-full, and offers the byte on the command stream. The first beat of a packet carries the first flag. Input-full clears in the cycle after the stream accepts the beat. An offered beat holds steady until it is accepted.
- R4: Writing 0x03 to address 1 in the command phase while input-full is clear offers a closing beat with the last flag set and data 0x00. Control-held is set while that beat waits.
- R5: In the command phase, a data write or an 0x03 write that arrives while input-full is set is dropped and raises the sticky overrun output. Data writes outside the command phase are ignored.
- R6: When the closing beat is accepted, the data register presents marker 0x01 with output-full and marker set (status 0x05).
- R7: Response bytes are accepted only in the response phase while output-full is clear. Each accepted byte is presented with output-full set and marker clear (status 0x01). Command and response streams are never both active.
- R8: A read of address 0 returns the waiting byte and clears output-full and marker. A read of address 0 with output-full clear returns 0xFF.
- R9: After the response byte flagged last has been read, marker 0x03 is presented with output-full and marker set. Reading it returns the port to idle with status 0x10.
- R10: Writing 0x22 to address 1 cancels from any state. From the next cycle the status reads exactly 0x10, address 0 reads 0xFF, the overrun and length-error outputs clear, and the abort output pulses for one cycle. A start written right after the cancel opens a new command.
- R11: The length-error output becomes set, and stays set, when a response ends with fewer than 6 bytes, or when its byte count differs from the big-endian 32-bit length in response bytes 2 to 5 (byte 2 most significant). A start code or a cancel clears it.
- R12: The 0x01 code holds input-full and control-held for exactly one cycle (status 0x2A, then 0x20) and produces no stream beat. A repeated 0x01 during a command leaves input-full clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 1 | Register select: 0 data, 1 status/control |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data (status or data register) |
| cmdValid | output | 1 | Command beat offered |
| cmdReady | input | 1 | Coprocessor takes the command beat |
| cmdData | output | 8 | Command byte (0x00 on the closing beat) |
| cmdFirst | output | 1 | First beat of the packet |
| cmdLast | output | 1 | Closing beat of the packet |
| cmdAbort | output | 1 | One-cycle pulse after a cancel |
| rspValid | input | 1 | Coprocessor offers a response byte |
| rspReady | output | 1 | Port takes the response byte |
| rspData | input | 8 | Response byte |
| rspLast | input | 1 | Final response byte |
| overrun | output | 1 | Sticky: a host write was dropped |
| rspLenBad | output | 1 | Sticky: response length invalid |

## Verification
The assertions check several properties on every cycle. An offered command beat and a waiting output byte stay unchanged until they are taken. The marker flag never appears without output-full. Idle implies both buffers are empty. The two device streams are never active together, and a cancel always yields status 0x10 in the following cycle. The bench's scenarios cover the rest: the full framing order of a packet, the drop-and-overrun case, the one-cycle life of the start code, recovery from a cancel followed straight away by a new start, and the length check for short and mismatched responses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_START = 8'h01;
  localparam logic [BYTE_W-1:0] CODE_END   = 8'h03;
  localparam logic [BYTE_W-1:0] CODE_ABORT = 8'h22;
  localparam logic [BYTE_W-1:0] EMPTY_READ = 8'hFF;
  localparam logic [BYTE_W-1:0] CLOSE_BEAT = 8'h00;

  // Response length field: bytes LEN_FIRST .. LEN_FIRST+LEN_BYTES-1, big-endian
  localparam int LEN_FIRST   = 2;
  localparam int LEN_BYTES   = 4;
  localparam int MIN_RSP_LEN = LEN_FIRST + LEN_BYTES;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_RSP,
    PH_CLOSE,
    PH_TAIL
  } phase_t;

  typedef struct packed {
    logic abort;
    logic takeStart;
    logic takePayload;
    logic takeEnd;
    logic dropWrite;
    logic loadOpen;
    logic loadClose;
    logic rspOpen;
    logic streamOn;
    logic hostPop;
  } strobe_t;

endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [BYTE_W-1:0] hostWdata,
  input  logic              inFull,
  input  logic              outFull,
  input  logic              endTaken,
  input  logic              lastTaken,
  output strobe_t           strb,
  output phase_t            phase
);

  phase_t phaseNext;
  logic   isCtrlWr;
  logic   isDataWr;
  logic   codeStart;
  logic   codeEnd;
  logic   codeAbort;

  assign isCtrlWr  = hostWr && hostAddr;
  assign isDataWr  = hostWr && !hostAddr;
  assign codeStart = isCtrlWr && (hostWdata == CODE_START);
  assign codeEnd   = isCtrlWr && (hostWdata == CODE_END);
  assign codeAbort = isCtrlWr && (hostWdata == CODE_ABORT);

  always_comb begin
    strb             = '0;
    strb.abort       = codeAbort;
    strb.takeStart   = codeStart && (phase == PH_IDLE) && !inFull;
    strb.takePayload = isDataWr && (phase == PH_CMD) && !inFull;
    strb.takeEnd     = codeEnd && (phase == PH_CMD) && !inFull;
    strb.dropWrite   = (phase == PH_CMD) && inFull && (isDataWr || codeEnd);
    strb.loadOpen    = (phase == PH_CMD) && endTaken;
    strb.loadClose   = (phase == PH_CLOSE) && !outFull;
    strb.rspOpen     = (phase == PH_RSP);
    strb.streamOn    = (phase == PH_CMD);
    strb.hostPop     = hostRd && !hostAddr;
  end

  always_comb begin
    phaseNext = phase;
    if (codeAbort) begin
      phaseNext = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  if (strb.takeStart)              phaseNext = PH_CMD;
        PH_CMD:   if (endTaken)                    phaseNext = PH_RSP;
        PH_RSP:   if (lastTaken)                   phaseNext = PH_CLOSE;
        PH_CLOSE: if (strb.loadClose)              phaseNext = PH_TAIL;
        PH_TAIL:  if (strb.hostPop && outFull)     phaseNext = PH_IDLE;
        default:                                   phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (!outFull && !inFull)); // R9

  AST_TAIL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_TAIL) |-> outFull); // R9

endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BYTE_W-1:0] hostWdata,
  input  logic              cmdReady,
  input  logic              rspValid,
  input  logic [BYTE_W-1:0] rspData,
  input  logic              rspLast,
  output logic              inFull,
  output logic              outFull,
  output logic              markFlag,
  output logic              ctrlHeld,
  output logic [BYTE_W-1:0] outByte,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdData,
  output logic              cmdFirst,
  output logic              cmdLast,
  output logic              rspReady,
  output logic              endTaken,
  output logic              lastTaken,
  output logic              overrun,
  output logic              badLen,
  output logic              abortPulse
);

  localparam int LEN_W = LEN_BYTES * BYTE_W;

  logic              inStart;
  logic              inEnd;
  logic [BYTE_W-1:0] inByte;
  logic              firstPend;
  logic              beatTaken;
  logic              rspTaken;
  logic [CNT_W-1:0]  rspCnt;
  logic [LEN_W-1:0]  lenNow;
  logic [31:0]       total32;
  logic              lenWrong;

  // Device-side stream views
  assign cmdValid  = strb.streamOn && inFull && !inStart;
  assign cmdData   = inEnd ? CLOSE_BEAT : inByte;
  assign cmdFirst  = firstPend;
  assign cmdLast   = inEnd;
  assign beatTaken = cmdValid && cmdReady;
  assign endTaken  = beatTaken && inEnd;
  assign ctrlHeld  = inFull && (inStart || inEnd);

  assign rspReady  = strb.rspOpen && !outFull;
  assign rspTaken  = rspReady && rspValid;
  assign lastTaken = rspTaken && rspLast;

  // Length-field capture, one lane per byte, most significant first
  for (genvar k = 0; k < LEN_BYTES; k++) begin : g_lenLane
    localparam int HI = LEN_W - 1 - k * BYTE_W;
    logic [BYTE_W-1:0] laneReg;
    logic              laneHit;

    assign laneHit = rspTaken && (rspCnt == CNT_W'(LEN_FIRST + k));
    assign lenNow[HI -: BYTE_W] = laneHit ? rspData : laneReg;

    always_ff @(posedge clk) begin
      if (!rstN)                              laneReg <= '0;
      else if (strb.abort || strb.takeStart)  laneReg <= '0;
      else if (laneHit)                       laneReg <= rspData;
    end
  end

  assign total32  = 32'(rspCnt) + 32'd1;
  assign lenWrong = (total32 < 32'(MIN_RSP_LEN)) || (total32 != 32'(lenNow));

  // Host-to-device holding register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFull    <= 1'b0;
      inStart   <= 1'b0;
      inEnd     <= 1'b0;
      inByte    <= '0;
      firstPend <= 1'b0;
      overrun   <= 1'b0;
    end else if (strb.abort) begin
      inFull    <= 1'b0;
      inStart   <= 1'b0;
      inEnd     <= 1'b0;
      firstPend <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (inFull && inStart) begin
        inFull  <= 1'b0;
        inStart <= 1'b0;
      end
      if (beatTaken) begin
        inFull    <= 1'b0;
        inEnd     <= 1'b0;
        firstPend <= 1'b0;
      end
      if (strb.takeStart) begin
        inFull    <= 1'b1;
        inStart   <= 1'b1;
        inEnd     <= 1'b0;
        firstPend <= 1'b1;
      end
      if (strb.takePayload) begin
        inFull  <= 1'b1;
        inStart <= 1'b0;
        inEnd   <= 1'b0;
        inByte  <= hostWdata;
      end
      if (strb.takeEnd) begin
        inFull  <= 1'b1;
        inStart <= 1'b0;
        inEnd   <= 1'b1;
      end
      if (strb.dropWrite) overrun <= 1'b1;
    end
  end

  // Device-to-host output register and response bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outFull    <= 1'b0;
      markFlag   <= 1'b0;
      outByte    <= '0;
      rspCnt     <= '0;
      badLen     <= 1'b0;
      abortPulse <= 1'b0;
    end else if (strb.abort) begin
      outFull    <= 1'b0;
      markFlag   <= 1'b0;
      rspCnt     <= '0;
      badLen     <= 1'b0;
      abortPulse <= 1'b1;
    end else begin
      abortPulse <= 1'b0;
      if (strb.takeStart) begin
        rspCnt <= '0;
        badLen <= 1'b0;
      end
      if (strb.loadOpen) begin
        outFull  <= 1'b1;
        markFlag <= 1'b1;
        outByte  <= CODE_START;
      end
      if (strb.hostPop && outFull) begin
        outFull  <= 1'b0;
        markFlag <= 1'b0;
      end
      if (rspTaken) begin
        outFull  <= 1'b1;
        markFlag <= 1'b0;
        outByte  <= rspData;
        if (rspCnt != '1) rspCnt <= rspCnt + 1'b1;
        if (rspLast && lenWrong) badLen <= 1'b1;
      end
      if (strb.loadClose) begin
        outFull  <= 1'b1;
        markFlag <= 1'b1;
        outByte  <= CODE_END;
      end
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady && !strb.abort) |=>
      (cmdValid && $stable(cmdData) && $stable(cmdLast))); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outFull && !strb.hostPop && !strb.abort) |=> (outFull && $stable(outByte))); // R8

  AST_MARK_FULL: assert property (@(posedge clk) disable iff (!rstN)
    markFlag |-> outFull); // R6

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, rspReady})); // R7

endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostAddr,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       cmdValid,
  input  logic       cmdReady,
  output logic [7:0] cmdData,
  output logic       cmdFirst,
  output logic       cmdLast,
  output logic       cmdAbort,
  input  logic       rspValid,
  output logic       rspReady,
  input  logic [7:0] rspData,
  input  logic       rspLast,
  output logic       overrun,
  output logic       rspLenBad
);

  strobe_t           strb;
  phase_t            phase;
  logic              inFull;
  logic              outFull;
  logic              markFlag;
  logic              ctrlHeld;
  logic              endTaken;
  logic              lastTaken;
  logic [BYTE_W-1:0] outByte;
  logic [BYTE_W-1:0] statusByte;

  mbox_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostAddr  (hostAddr),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .hostWdata (hostWdata),
    .inFull    (inFull),
    .outFull   (outFull),
    .endTaken  (endTaken),
    .lastTaken (lastTaken),
    .strb      (strb),
    .phase     (phase)
  );

  mbox_dpath #(.CNT_W(CNT_W)) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostWdata  (hostWdata),
    .cmdReady   (cmdReady),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspLast    (rspLast),
    .inFull     (inFull),
    .outFull    (outFull),
    .markFlag   (markFlag),
    .ctrlHeld   (ctrlHeld),
    .outByte    (outByte),
    .cmdValid   (cmdValid),
    .cmdData    (cmdData),
    .cmdFirst   (cmdFirst),
    .cmdLast    (cmdLast),
    .rspReady   (rspReady),
    .endTaken   (endTaken),
    .lastTaken  (lastTaken),
    .overrun    (overrun),
    .badLen     (rspLenBad),
    .abortPulse (cmdAbort)
  );

  assign statusByte = {2'b00, (phase == PH_CMD), (phase == PH_IDLE),
                       ctrlHeld, markFlag, inFull, outFull};

  assign hostRdata = hostAddr ? statusByte : (outFull ? outByte : EMPTY_READ);

  AST_CANCEL_READY: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr && (hostWdata == CODE_ABORT)) |=> (statusByte == 8'h10)); // R10

  AST_START_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr && (hostWdata == CODE_START) && statusByte[4]) |=>
      (statusByte[1] && statusByte[3] && !cmdValid)); // R12

endmodule

// File: tb/test_mbox_port.sv
`timescale 1ns/1ps
module test_mbox_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostAddr = 1'b1;
  logic       hostRd = 1'b0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       cmdValid;
  logic       cmdReady = 1'b0;
  logic [7:0] cmdData;
  logic       cmdFirst;
  logic       cmdLast;
  logic       cmdAbort;
  logic       rspValid = 1'b0;
  logic       rspReady;
  logic [7:0] rspData = 8'h00;
  logic       rspLast = 1'b0;
  logic       overrun;
  logic       rspLenBad;

  always #2 clk = ~clk;

  mbox_port i_mbox_port (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdData(cmdData), .cmdFirst(cmdFirst), .cmdLast(cmdLast),
    .cmdAbort(cmdAbort), .rspValid(rspValid), .rspReady(rspReady), .rspData(rspData),
    .rspLast(rspLast), .overrun(overrun), .rspLenBad(rspLenBad)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] lastRd;

  // Behavioural reference model
  int         mPh = 0;          // 0 idle, 1 command, 2 response, 3 closing, 4 tail
  bit         mInFull, mInStart, mInEnd, mFirst;
  logic [7:0] mInByte;
  bit         mOutFull, mMark;
  logic [7:0] mOutByte;
  bit         mOvr, mBad, mAbort;
  int         mCnt;
  logic [31:0] mLen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] mStatus();
    return {2'b00, mPh == 1, mPh == 0, mInFull && (mInStart || mInEnd),
            mMark, mInFull, mOutFull};
  endfunction

  task automatic modelStep();
    bit cancel, vIn, accept, racc, pop, preFull, preOut;
    int prePh;
    cancel  = hostWr && hostAddr && hostWdata == 8'h22;
    vIn     = (mPh == 1) && mInFull && !mInStart;
    accept  = vIn && cmdReady;
    racc    = (mPh == 2) && !mOutFull && rspValid;
    pop     = hostRd && !hostAddr;
    preFull = mInFull; preOut = mOutFull; prePh = mPh;
    if (cancel) begin
      mPh = 0; mInFull = 0; mInStart = 0; mInEnd = 0; mFirst = 0;
      mOutFull = 0; mMark = 0; mOvr = 0; mBad = 0; mCnt = 0; mLen = 0; mAbort = 1;
      return;
    end
    mAbort = 0;
    if (mInFull && mInStart) begin mInFull = 0; mInStart = 0; end
    if (accept) begin
      mInFull = 0; mFirst = 0;
      if (mInEnd) begin
        mInEnd = 0; mPh = 2; mOutFull = 1; mMark = 1; mOutByte = 8'h01;
      end
    end
    if (hostWr && !hostAddr && prePh == 1) begin
      if (preFull) mOvr = 1;
      else begin mInFull = 1; mInByte = hostWdata; mInEnd = 0; end
    end
    if (hostWr && hostAddr && hostWdata == 8'h01 && prePh == 0) begin
      mInFull = 1; mInStart = 1; mInEnd = 0; mFirst = 1; mPh = 1;
      mBad = 0; mCnt = 0; mLen = 0;
    end
    if (hostWr && hostAddr && hostWdata == 8'h03 && prePh == 1) begin
      if (preFull) mOvr = 1;
      else begin mInFull = 1; mInEnd = 1; end
    end
    if (pop && preOut) begin
      mOutFull = 0; mMark = 0;
      if (prePh == 4) mPh = 0;
    end
    if (racc) begin
      mOutFull = 1; mMark = 0; mOutByte = rspData;
      if (mCnt >= 2 && mCnt <= 5) mLen[(5 - mCnt) * 8 +: 8] = rspData;
      if (rspLast) begin
        if ((mCnt + 1) < 6 || (mCnt + 1) != int'(mLen)) mBad = 1;
        mPh = 3;
      end
      mCnt++;
    end
    if (prePh == 3 && !preOut) begin
      mOutFull = 1; mMark = 1; mOutByte = 8'h03; mPh = 4;
    end
  endtask

  task automatic tick();
    bit expV;
    #0.5;
    lastRd = hostRdata;
    expV = (mPh == 1) && mInFull && !mInStart;
    if (hostAddr) chk("R1 status", hostRdata, mStatus());
    else          chk("R8 data read", hostRdata, mOutFull ? mOutByte : 8'hFF);
    chk("R3 cmdValid", cmdValid, expV);
    if (expV) begin
      chk("R3 cmdData", cmdData, mInEnd ? 8'h00 : mInByte);
      chk("R3 cmdFirst", cmdFirst, mFirst);
      chk("R4 cmdLast", cmdLast, mInEnd);
    end
    chk("R7 rspReady", rspReady, (mPh == 2) && !mOutFull);
    chk("R5 overrun", overrun, mOvr);
    chk("R11 rspLenBad", rspLenBad, mBad);
    chk("R10 cmdAbort", cmdAbort, mAbort);
    @(posedge clk);
    modelStep();
    @(negedge clk);
  endtask

  task automatic hwr(input logic a, input logic [7:0] d);
    hostAddr = a; hostWr = 1'b1; hostWdata = d;
    tick();
    hostWr = 1'b0; hostAddr = 1'b1;
  endtask

  task automatic hrd(output logic [7:0] v);
    hostAddr = 1'b0; hostRd = 1'b1;
    tick();
    v = lastRd;
    hostRd = 1'b0; hostAddr = 1'b1;
  endtask

  task automatic stat(input string req, input logic [7:0] exp);
    #0.5;
    chk(req, hostRdata, exp);
  endtask

  // Sends a response byte by byte, reading each back, then collects the end marker
  task automatic sendRsp(input logic [7:0] bytes[$]);
    logic [7:0] v;
    foreach (bytes[i]) begin
      rspValid = 1'b1; rspData = bytes[i]; rspLast = (i == bytes.size() - 1);
      tick();
      rspValid = 1'b0; rspLast = 1'b0;
      stat("R7 payload status", 8'h01);
      hrd(v);
      chk("R7 payload byte", v, bytes[i]);
    end
    tick();
    stat("R9 end marker status", 8'h05);
    hrd(v);
    chk("R9 end marker", v, 8'h03);
    stat("R9 back to idle", 8'h10);
  endtask

  task automatic openAndClose();
    hwr(1'b1, 8'h01);
    tick();
    cmdReady = 1'b1;
    hwr(1'b1, 8'h03);
    tick();
    cmdReady = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    mInByte = 0; mOutByte = 0; mLen = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    stat("R1 reset status", 8'h10);

    // Data write while idle is ignored
    hwr(1'b0, 8'h77);
    stat("R5 idle write ignored", 8'h10);

    // Open a command
    hwr(1'b1, 8'h01);
    stat("R12 start held", 8'h2A);
    chk("R12 no beat", cmdValid, 1'b0);
    tick();
    stat("R2 command phase", 8'h20);
    hwr(1'b1, 8'h01);
    stat("R12 repeat start ignored", 8'h20);

    // Payload with a stalled consumer and an overrun
    hwr(1'b0, 8'hA5);
    stat("R3 byte held", 8'h22);
    chk("R3 first beat data", cmdData, 8'hA5);
    chk("R3 first flag", cmdFirst, 1'b1);
    hwr(1'b0, 8'h5A);
    chk("R5 overrun raised", overrun, 1'b1);
    tick();
    cmdReady = 1'b1;
    tick();
    stat("R3 input released", 8'h20);
    hwr(1'b0, 8'h3C);
    chk("R3 second beat not first", cmdFirst, 1'b0);
    tick();
    cmdReady = 1'b0;
    hwr(1'b1, 8'h03);
    stat("R4 closing beat held", 8'h2A);
    chk("R4 closing data", cmdData, 8'h00);
    chk("R4 closing last", cmdLast, 1'b1);
    cmdReady = 1'b1;
    tick();
    cmdReady = 1'b0;
    stat("R6 start marker", 8'h05);

    // Response byte offered while the marker waits is not taken
    rspValid = 1'b1; rspData = 8'h99;
    #0.5;
    chk("R7 blocked while full", rspReady, 1'b0);
    rspValid = 1'b0;
    hrd(v);
    chk("R6 marker value", v, 8'h01);
    hrd(v);
    chk("R8 empty read", v, 8'hFF);

    // Well-formed 8-byte response (length field = 8)
    sendRsp('{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h08, 8'h11, 8'h22});
    chk("R11 good length", rspLenBad, 1'b0);

    // Short response
    openAndClose();
    hrd(v);
    sendRsp('{8'h00, 8'hC4, 8'h00});
    chk("R11 short response", rspLenBad, 1'b1);

    // Start clears the error; then a mismatched length field
    openAndClose();
    chk("R11 cleared by start", rspLenBad, 1'b0);
    hrd(v);
    sendRsp('{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h07});
    chk("R11 length mismatch", rspLenBad, 1'b1);

    // Cancel during a response with a byte waiting
    openAndClose();
    hwr(1'b1, 8'h22);
    stat("R10 status after cancel", 8'h10);
    chk("R10 abort pulse", cmdAbort, 1'b1);
    chk("R10 length error cleared", rspLenBad, 1'b0);
    hostAddr = 1'b0;
    #0.5;
    chk("R10 data empty after cancel", hostRdata, 8'hFF);
    hostAddr = 1'b1;
    tick();
    chk("R10 abort one cycle", cmdAbort, 1'b0);

    // Cancel mid-command followed at once by a new start
    hwr(1'b1, 8'h01);
    hwr(1'b0, 8'h10);
    hwr(1'b0, 8'h20);
    chk("R5 overrun mid command", overrun, 1'b1);
    hwr(1'b1, 8'h22);
    chk("R10 overrun cleared", overrun, 1'b0);
    hwr(1'b1, 8'h01);
    stat("R10 restart after cancel", 8'h2A);
    tick();
    cmdReady = 1'b1;
    hwr(1'b0, 8'h42);
    chk("R3 restart first beat", cmdFirst, 1'b1);
    tick();
    hwr(1'b1, 8'h03);
    tick();
    cmdReady = 1'b0;
    hrd(v);
    chk("R6 marker after restart", v, 8'h01);
    sendRsp('{8'h00, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h06});
    chk("R11 exact minimum length", rspLenBad, 1'b0);
    repeat (3) tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule